// File: doc/BRIEF.md
# Periodic Countdown Interrupt Timer

This block is a programmable 16-bit down-counter that raises a periodic interrupt request toward a host. A prescaler divides the system clock by `CLK_PER_TICK` to make a fixed-rate tick; with the default of 5000 and a 50 MHz clock, one tick lasts 100 µs. The counter moves down by one on each tick while the timer is running.

Software drives the timer through a set of field strobes. These write the run bit, the 16-bit start value, the interrupt enable, and a write-one-to-clear strobe for the sticky status flag. The current count, the stored start value, both control bits and the status flag can all be read back at the ports.

When the counter passes zero it wraps to FFFFh rather than reloading, and it keeps counting. The same event sets the status flag, provided interrupts are enabled. The request output follows the status flag gated by the interrupt enable.

Top module: `countdown_irq_timer`

## Requirements
- R1: After reset the count reads FFFFh, the stored start value reads 0000h, and the run bit, the interrupt enable, the status flag and `irq` all read 0.
- R2: While running, the count drops by exactly one every `CLK_PER_TICK` clock cycles and holds its value between ticks.
- R3: Writing the run bit from 0 to 1 puts the stored start value into the count and restarts the prescaler from zero. If the start value is written in the same cycle, the new start value is used.
- R4: Writing the run bit from 1 to 0 returns the count to FFFFh. While the timer is stopped, the count stays at FFFFh.
- R5: The start value may be written at any time. While the timer is stopped the write does not change the count. While it runs, the count takes the new value at once and the prescaler restarts.
- R6: A tick that finds the count at 0000h changes it to FFFFh, and counting continues from there.
- R7: A wrap sets the status flag only when the interrupt enable is 1. With the enable at 0 the flag stays 0.
- R8: The status flag is sticky. A clear strobe with data 1 clears it, and a clear strobe with data 0 leaves it as it is.
- R9: If a wrap that would set the flag and a clear strobe with data 1 happen in the same cycle, the flag ends up set.
- R10: `irq` is 1 exactly when the status flag and the interrupt enable are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en_wr | input | 1 | Strobe: write the run bit |
| en_wdata | input | 1 | New value of the run bit |
| ld_wr | input | 1 | Strobe: write the start value |
| ld_wdata | input | 16 | New start value |
| ie_wr | input | 1 | Strobe: write the interrupt enable |
| ie_wdata | input | 1 | New interrupt enable value |
| clr_wr | input | 1 | Strobe: write to the status flag (1 clears) |
| clr_wdata | input | 1 | Data for the status write |
| count | output | 16 | Current counter value |
| preload | output | 16 | Stored start value |
| enabled | output | 1 | Run bit |
| int_en | output | 1 | Interrupt enable |
| status | output | 1 | Sticky wrap status flag |
| irq | output | 1 | Interrupt request |

## Verification
The counting path is driven from a table of start values paired with tick counts. Some entries stop short of zero, some land exactly on zero, some start at zero, and some run several ticks past the wrap. Together they separate a correct decrement from an early or late wrap, from a reload-on-wrap variant, and from a status flag set one tick too soon. Directed sequences then check the following:
- a start-value write while running, sampled one cycle before and at the first tick after it, to expose a prescaler that is not restarted;
- a wrap with interrupts disabled;
- clear strobes with data 0 and with data 1;
- a clear that lands in the same cycle as a wrap.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
  parameter int unsigned CNT_W = 16;
  typedef logic [CNT_W-1:0] cnt_t;

  localparam cnt_t CNT_PARK = '1;

  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,
    ACT_PARK = 2'd1,
    ACT_LOAD = 2'd2,
    ACT_STEP = 2'd3
  } act_e;

  // one tick of the count: the step below zero lands on all ones
  function automatic cnt_t cnt_step(input cnt_t c);
    return c - cnt_t'(1);
  endfunction

  function automatic logic cnt_at_floor(input cnt_t c);
    return c == '0;
  endfunction
endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
  parameter int unsigned CLK_PER_TICK = 5000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  output logic tick
);
  localparam int unsigned PRE_W = (CLK_PER_TICK > 1) ? $clog2(CLK_PER_TICK) : 1;
  localparam logic [PRE_W-1:0] LAST = PRE_W'(CLK_PER_TICK - 1);

  logic [PRE_W-1:0] pre_q;

  assign tick = run && !restart && (pre_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_q <= '0;
    end else if (restart || !run || tick) begin
      pre_q <= '0;
    end else begin
      pre_q <= pre_q + PRE_W'(1);
    end
  end

  // R2: a tick never comes within the first period after a restart
  p_no_early_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !tick);
endmodule

// File: rtl/countdown_core.sv
module countdown_core
  import cdt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en_wr,
  input  logic en_wdata,
  input  logic ld_wr,
  input  cnt_t ld_wdata,
  input  logic tick,
  output cnt_t count,
  output cnt_t preload,
  output logic enabled,
  output logic restart_ev,
  output logic wrap_ev
);
  logic en_q;
  cnt_t cnt_q, pre_q, load_val;
  logic rise_ev, fall_ev, reload_ev;
  act_e act;

  assign rise_ev    = en_wr && en_wdata && !en_q;
  assign fall_ev    = en_wr && !en_wdata && en_q;
  assign reload_ev  = ld_wr && en_q && !fall_ev;
  assign restart_ev = rise_ev || fall_ev || reload_ev;
  assign load_val   = ld_wr ? ld_wdata : pre_q;
  assign wrap_ev    = tick && cnt_at_floor(cnt_q);

  always_comb begin
    if (fall_ev)                   act = ACT_PARK;
    else if (rise_ev || reload_ev) act = ACT_LOAD;
    else if (tick)                 act = ACT_STEP;
    else                           act = ACT_HOLD;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      pre_q <= '0;
      cnt_q <= CNT_PARK;
    end else begin
      if (en_wr) en_q <= en_wdata;
      if (ld_wr) pre_q <= ld_wdata;
      unique case (act)
        ACT_PARK: cnt_q <= CNT_PARK;
        ACT_LOAD: cnt_q <= load_val;
        ACT_STEP: cnt_q <= cnt_step(cnt_q);
        default:  cnt_q <= cnt_q;
      endcase
    end
  end

  assign count   = cnt_q;
  assign preload = pre_q;
  assign enabled = en_q;

  // R4: stopped timer sits at all ones
  p_park_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !enabled |-> count == CNT_PARK);
  // R2: a plain tick above zero lowers the count by one
  p_dec_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !restart_ev && count != '0) |=> count == $past(count) - cnt_t'(1));
  // R6: a tick at zero wraps to all ones
  p_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_ev |=> count == CNT_PARK);
  // R3: start from the written or stored start value
  p_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rise_ev |=> count == $past(ld_wr ? ld_wdata : preload));
endmodule

// File: rtl/irq_status.sv
module irq_status (
  input  logic clk,
  input  logic rst_n,
  input  logic wrap_ev,
  input  logic ie_wr,
  input  logic ie_wdata,
  input  logic clr_wr,
  input  logic clr_wdata,
  output logic status,
  output logic int_en,
  output logic irq
);
  logic ie_q, sts_q, set_ev, clr_ev;

  assign set_ev = wrap_ev && ie_q;
  assign clr_ev = clr_wr && clr_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ie_q  <= 1'b0;
      sts_q <= 1'b0;
    end else begin
      if (ie_wr) ie_q <= ie_wdata;
      if (set_ev)      sts_q <= 1'b1;
      else if (clr_ev) sts_q <= 1'b0;
    end
  end

  assign status = sts_q;
  assign int_en = ie_q;
  assign irq    = sts_q && ie_q;

  // R8: without a clear the flag holds
  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (status && !clr_ev) |=> status);
  // R9: set beats clear
  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    set_ev |=> status);
  // R7: flag rises only from a wrap with the enable on
  p_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status) |-> $past(wrap_ev && int_en));
endmodule

// File: rtl/countdown_irq_timer.sv
module countdown_irq_timer #(
  parameter int unsigned CLK_PER_TICK = 5000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        en_wr,
  input  logic        en_wdata,
  input  logic        ld_wr,
  input  logic [15:0] ld_wdata,
  input  logic        ie_wr,
  input  logic        ie_wdata,
  input  logic        clr_wr,
  input  logic        clr_wdata,
  output logic [15:0] count,
  output logic [15:0] preload,
  output logic        enabled,
  output logic        int_en,
  output logic        status,
  output logic        irq
);
  logic tick, restart_ev, wrap_ev;

  tick_prescaler #(.CLK_PER_TICK(CLK_PER_TICK)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(enabled), .restart(restart_ev), .tick(tick)
  );

  countdown_core u_core (
    .clk(clk), .rst_n(rst_n), .en_wr(en_wr), .en_wdata(en_wdata),
    .ld_wr(ld_wr), .ld_wdata(ld_wdata), .tick(tick),
    .count(count), .preload(preload), .enabled(enabled),
    .restart_ev(restart_ev), .wrap_ev(wrap_ev)
  );

  irq_status u_sts (
    .clk(clk), .rst_n(rst_n), .wrap_ev(wrap_ev),
    .ie_wr(ie_wr), .ie_wdata(ie_wdata), .clr_wr(clr_wr), .clr_wdata(clr_wdata),
    .status(status), .int_en(int_en), .irq(irq)
  );

  // R10: request only with both flag and enable
  p_irq_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (status && int_en));
endmodule

// File: tb/sim_countdown_irq_timer.sv
module sim_countdown_irq_timer;
  localparam int N = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en_wr = 0, en_wdata = 0, ld_wr = 0, ie_wr = 0, ie_wdata = 0, clr_wr = 0, clr_wdata = 0;
  logic [15:0] ld_wdata = '0;
  logic [15:0] count, preload;
  logic enabled, int_en, status, irq;
  int total = 0, bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  countdown_irq_timer #(.CLK_PER_TICK(N)) u0 (
    .clk(clk), .rst_n(rst_n), .en_wr(en_wr), .en_wdata(en_wdata),
    .ld_wr(ld_wr), .ld_wdata(ld_wdata), .ie_wr(ie_wr), .ie_wdata(ie_wdata),
    .clr_wr(clr_wr), .clr_wdata(clr_wdata), .count(count), .preload(preload),
    .enabled(enabled), .int_en(int_en), .status(status), .irq(irq)
  );

  typedef struct packed {
    logic [15:0] start;
    logic [7:0]  ticks;
    logic [15:0] exp_cnt;
    logic        exp_sts;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{16'd5, 8'd2, 16'd3,      1'b0},
    '{16'd1, 8'd1, 16'd0,      1'b0},
    '{16'd1, 8'd2, 16'hFFFF,   1'b1},
    '{16'd0, 8'd1, 16'hFFFF,   1'b1},
    '{16'd0, 8'd3, 16'hFFFD,   1'b1},
    '{16'd3, 8'd3, 16'd0,      1'b0},
    '{16'd2, 8'd5, 16'hFFFD,   1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_en(input logic b);
    en_wr = 1; en_wdata = b; @(negedge clk); en_wr = 0;
  endtask
  task automatic wr_ld(input logic [15:0] v);
    ld_wr = 1; ld_wdata = v; @(negedge clk); ld_wr = 0;
  endtask
  task automatic wr_ie(input logic b);
    ie_wr = 1; ie_wdata = b; @(negedge clk); ie_wr = 0;
  endtask
  task automatic wr_clr(input logic b);
    clr_wr = 1; clr_wdata = b; @(negedge clk); clr_wr = 0;
  endtask
  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    wait_cyc(3);
    rst_n = 1;
    wait_cyc(1);
    // R1 reset state
    chk("R1 count", count, 16'hFFFF);
    chk("R1 preload", preload, 0);
    chk("R1 flags", {enabled, int_en, status, irq}, 0);

    // R5: start-value write while stopped leaves the count
    wr_ld(16'd9);
    chk("R5 stopped count", count, 16'hFFFF);
    chk("R5 stored", preload, 16'd9);
    // R3: enabling loads the start value
    wr_en(1);
    chk("R3 load", count, 16'd9);
    wait_cyc(N - 1);
    chk("R2 hold between ticks", count, 16'd9);
    wait_cyc(1);
    chk("R2 one tick", count, 16'd8);
    // R4: disabling parks
    wr_en(0);
    chk("R4 park", count, 16'hFFFF);
    wait_cyc(3 * N);
    chk("R4 stays parked", count, 16'hFFFF);

    // R5: rewrite while running restarts
    wr_ie(1);
    wr_en(1);
    wait_cyc(2 * N);
    chk("R2 two ticks", count, 16'd7);
    wr_ld(16'd20);
    chk("R5 reload", count, 16'd20);
    wait_cyc(N - 1);
    chk("R5 prescaler restarted", count, 16'd20);
    wait_cyc(1);
    chk("R5 first tick after reload", count, 16'd19);

    // table: R2, R6, R7, R10
    foreach (VECS[i]) begin
      wr_en(0);
      wr_clr(1);
      wr_ld(VECS[i].start);
      wr_en(1);
      wait_cyc(N * int'(VECS[i].ticks));
      chk("R6 vector count", count, VECS[i].exp_cnt);
      chk("R7 vector status", status, VECS[i].exp_sts);
      chk("R10 vector irq", irq, VECS[i].exp_sts);
    end

    // R7: no flag with the enable off
    wr_en(0);
    wr_clr(1);
    wr_ie(0);
    wr_ld(16'd1);
    wr_en(1);
    wait_cyc(2 * N);
    chk("R7 wrap count", count, 16'hFFFF);
    chk("R7 no status", status, 0);
    chk("R10 no irq", irq, 0);

    // R8 / R10
    wr_ie(1);
    wr_en(0);
    wr_ld(16'd0);
    wr_en(1);
    wait_cyc(N);
    chk("R7 status set", status, 1);
    chk("R10 irq on", irq, 1);
    wr_clr(0);
    chk("R8 write 0 keeps", status, 1);
    wr_ie(0);
    chk("R10 irq masked", irq, 0);
    chk("R8 status kept when masked", status, 1);
    wr_ie(1);
    chk("R10 irq back", irq, 1);
    wr_clr(1);
    chk("R8 write 1 clears", status, 0);
    chk("R10 irq cleared", irq, 0);

    // R9: clear in the wrap cycle
    wr_en(0);
    wr_ld(16'd0);
    wr_en(1);
    wait_cyc(N - 1);
    wr_clr(1);
    chk("R9 set wins", status, 1);
    chk("R6 wrap with clear", count, 16'hFFFF);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule